// File: doc/BRIEF.md
# Floor-Skipping Elevator Target Controller

This block chooses where an elevator car should travel after a floor button is pressed in a building with four floors. It keeps the car's present floor in a register and accepts a single-cycle request strobe together with the requested floor. One clock later it issues the chosen target floor with a strobe.

Short trips are discouraged. A request for a floor directly above or below the car is refused, and the car stays put. A request for the car's own floor returns that floor. Any request two or more floors away is granted.

A granted move stays outstanding until the car reports arrival. The arrival loads the target into the present-floor register. While a move is outstanding, new requests are dropped. Each request is judged on its own, and nothing is queued.

Top module: `elev_target_ctrl`

## Requirements
- R1: After a synchronous active-high reset, cur_floor is 0 (floors are binary indices 0 to 3), busy is 0, tgt_valid is 0 and refused is 0.
- R2: An accepted request for the car's present floor yields tgt_floor equal to cur_floor with refused low, and busy stays 0.
- R3: An accepted request whose floor differs from cur_floor by exactly one yields tgt_floor equal to cur_floor with refused high, and busy stays 0.
- R4: An accepted request whose floor differs from cur_floor by two or more yields tgt_floor equal to the requested floor with refused low, and busy becomes 1.
- R5: A request is accepted when req_valid is high and busy is low. tgt_valid pulses for exactly one cycle, in the cycle after the accepted request.
- R6: A request presented while busy is 1 is ignored. No tgt_valid follows it, and tgt_floor, cur_floor and busy are unchanged by it.
- R7: A pulse on arrive while busy is 1 loads the outstanding target into cur_floor and clears busy, both visible in the next cycle.
- R8: A pulse on arrive while busy is 0 leaves cur_floor unchanged.
- R9: refused is never high unless tgt_valid is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Single-cycle floor button strobe |
| req_floor | input | 2 | Requested floor index |
| arrive | input | 1 | Car has reached the outstanding target |
| tgt_valid | output | 1 | Target decision strobe |
| tgt_floor | output | 2 | Floor the car should go to |
| refused | output | 1 | The strobed request was an adjacent-floor request and was refused |
| cur_floor | output | 2 | Present floor of the car |
| busy | output | 1 | A granted move awaits arrive |

## Verification
The bench targets the following corner cases, and the failure each would expose:
- Requests at the edge floors 0 and 3, where a wrong distance computation (wrap-around or signed error) would grant a one-floor hop or refuse a two-floor trip.
- Requests made while a move is outstanding. A design that ignored busy would emit a fresh target and overwrite the pending one.
- Arrive pulses with no move pending. A careless design would reload the present floor from a stale target.
- Same-floor requests. A design that treated them as moves would raise busy and then wait for an arrival that never comes.

Random traffic from a fixed seed covers every present/requested floor pairing against a bench reference model.

// File: rtl/elev_pkg.sv
package elev_pkg;

    parameter int unsigned FLOORS  = 4;
    localparam int unsigned FLOOR_W = $clog2(FLOORS);

    typedef logic [FLOOR_W-1:0] floor_t;

    typedef enum logic [1:0] {
        VERDICT_STAY  = 2'd0,
        VERDICT_NEAR  = 2'd1,
        VERDICT_GO    = 2'd2
    } verdict_kind_e;

    typedef struct packed {
        verdict_kind_e kind;
        floor_t        dest;
    } verdict_t;

    function automatic floor_t floor_gap(input floor_t a, input floor_t b);
        return (a > b) ? floor_t'(a - b) : floor_t'(b - a);
    endfunction

endpackage

// File: rtl/elev_decide.sv
module elev_decide
    import elev_pkg::*;
#(
    parameter int unsigned MIN_HOP = 2
) (
    input  floor_t   here,
    input  floor_t   wanted,
    output verdict_t verdict
);
    floor_t gap;

    always_comb begin
        gap = floor_gap(here, wanted);
        if (gap == '0) begin
            verdict.kind = VERDICT_STAY;
            verdict.dest = here;
        end else if (int'(gap) < int'(MIN_HOP)) begin
            verdict.kind = VERDICT_NEAR;
            verdict.dest = here;
        end else begin
            verdict.kind = VERDICT_GO;
            verdict.dest = wanted;
        end
    end
endmodule

// File: rtl/elev_issue.sv
module elev_issue
    import elev_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  verdict_t verdict,
    output logic     tgt_valid,
    output floor_t   tgt_floor,
    output logic     refused
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_valid <= 1'b0;
            tgt_floor <= '0;
            refused   <= 1'b0;
        end else begin
            tgt_valid <= accept;
            refused   <= accept && (verdict.kind == VERDICT_NEAR);
            if (accept) begin
                tgt_floor <= verdict.dest;
            end
        end
    end

    // R9: refusal is only flagged together with a strobe
    a_r9_refused_with_strobe: assert property (@(posedge clk) disable iff (rst)
        refused |-> tgt_valid);
endmodule

// File: rtl/elev_position.sv
module elev_position
    import elev_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch,
    input  floor_t launch_floor,
    input  logic   arrive,
    output floor_t cur_floor,
    output logic   busy
);
    floor_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_floor <= '0;
            busy      <= 1'b0;
            pending   <= '0;
        end else begin
            if (launch) begin
                busy    <= 1'b1;
                pending <= launch_floor;
            end else if (busy && arrive) begin
                busy      <= 1'b0;
                cur_floor <= pending;
            end
        end
    end

    // R8: arrival with nothing pending leaves the floor alone
    a_r8_idle_arrive_noop: assert property (@(posedge clk) disable iff (rst)
        (!busy && arrive) |=> (cur_floor == $past(cur_floor)));
endmodule

// File: rtl/elev_target_ctrl.sv
module elev_target_ctrl
    import elev_pkg::*;
#(
    parameter int unsigned MIN_HOP = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [FLOOR_W-1:0]     req_floor,
    input  logic                   arrive,
    output logic                   tgt_valid,
    output logic [FLOOR_W-1:0]     tgt_floor,
    output logic                   refused,
    output logic [FLOOR_W-1:0]     cur_floor,
    output logic                   busy
);
    verdict_t verdict;
    logic     accept;
    logic     launch;
    floor_t   cur_q;
    floor_t   tgt_q;

    assign accept = req_valid && !busy;
    assign launch = accept && (verdict.kind == VERDICT_GO);

    elev_decide #(.MIN_HOP(MIN_HOP)) u_decide (
        .here    (cur_q),
        .wanted  (req_floor),
        .verdict (verdict)
    );

    elev_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .verdict   (verdict),
        .tgt_valid (tgt_valid),
        .tgt_floor (tgt_q),
        .refused   (refused)
    );

    elev_position u_position (
        .clk          (clk),
        .rst          (rst),
        .launch       (launch),
        .launch_floor (verdict.dest),
        .arrive       (arrive),
        .cur_floor    (cur_q),
        .busy         (busy)
    );

    assign cur_floor = cur_q;
    assign tgt_floor = tgt_q;

    // R5: a request seen while idle is answered in the next cycle
    a_r5_strobe_follows_request: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> tgt_valid);

    // R6: a request seen while busy gets no answer
    a_r6_busy_drops_request: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> !tgt_valid);

    // R3: a refused request keeps the car where it is
    a_r3_refused_stays: assert property (@(posedge clk) disable iff (rst)
        refused |-> (tgt_floor == cur_floor) && !busy);

    // R7: arrival lands the car on the outstanding target
    a_r7_arrive_loads_target: assert property (@(posedge clk) disable iff (rst)
        (busy && arrive) |=> (!busy && cur_floor == $past(tgt_floor)));

    // R4: a granted move to another floor leaves a move outstanding
    a_r4_go_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && !refused && tgt_floor != cur_floor) |-> busy);
endmodule

// File: tb/test_elev_target_ctrl.sv
module test_elev_target_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [1:0] req_floor;
    logic       arrive;
    logic       tgt_valid;
    logic [1:0] tgt_floor;
    logic       refused;
    logic [1:0] cur_floor;
    logic       busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_cur;
    logic [1:0] m_tgt;
    logic       m_busy;

    always #2 clk = ~clk;

    elev_target_ctrl i_elev_target_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_floor (req_floor),
        .arrive    (arrive),
        .tgt_valid (tgt_valid),
        .tgt_floor (tgt_floor),
        .refused   (refused),
        .cur_floor (cur_floor),
        .busy      (busy)
    );

    function automatic int gap_of(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? int'(a) - int'(b) : int'(b) - int'(a);
    endfunction

    function automatic logic [1:0] want_target(input logic [1:0] here, input logic [1:0] rq);
        return (gap_of(here, rq) >= 2) ? rq : here;
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // drive one cycle, then compare every output to the model
    task automatic step(input bit rq, input logic [1:0] fl, input bit arr, input string tag);
        bit acc;
        bit e_ref;
        logic [1:0] nxt;
        @(negedge clk);
        req_valid = rq;
        req_floor = fl;
        arrive    = arr;
        acc   = rq && !m_busy;
        e_ref = acc && (gap_of(m_cur, fl) == 1);
        nxt   = want_target(m_cur, fl);
        if (acc) begin
            m_tgt = nxt;
            if (nxt != m_cur) m_busy = 1'b1;
        end else if (m_busy && arr) begin
            m_cur  = m_tgt;
            m_busy = 1'b0;
        end
        @(posedge clk);
        #1;
        check(tag, int'(tgt_valid), int'(acc), "tgt_valid");
        check(tag, int'(refused), int'(e_ref), "refused");
        check(tag, int'(cur_floor), int'(m_cur), "cur_floor");
        check(tag, int'(busy), int'(m_busy), "busy");
        check(tag, int'(tgt_floor), int'(m_tgt), "tgt_floor");
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; req_floor = 2'd0; arrive = 1'b0;
        m_cur = 2'd0; m_tgt = 2'd0; m_busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", int'(cur_floor), 0, "cur_floor");
        check("R1", int'(busy), 0, "busy");
        check("R1", int'(tgt_valid), 0, "tgt_valid");
        check("R1", int'(refused), 0, "refused");

        step(1, 2'd1, 0, "R3 up one from 0");
        step(0, 2'd0, 0, "R5 strobe one cycle");
        step(1, 2'd0, 0, "R2 same floor 0");
        step(0, 2'd0, 1, "R8 arrive idle");
        step(1, 2'd2, 0, "R4 go to 2");
        step(1, 2'd3, 0, "R6 request while busy");
        step(1, 2'd0, 0, "R6 second request while busy");
        step(0, 2'd0, 1, "R7 arrive at 2");
        step(1, 2'd3, 0, "R3 up one from 2");
        step(1, 2'd1, 0, "R3 down one from 2");
        step(1, 2'd0, 0, "R4 go to 0");
        step(1, 2'd0, 1, "R6 request with arrive");
        step(1, 2'd3, 0, "R4 go to 3 from 0");
        step(0, 2'd0, 1, "R7 arrive at 3");
        step(1, 2'd2, 0, "R3 down one from 3");
        step(1, 2'd3, 0, "R2 same floor 3");
        step(1, 2'd1, 0, "R4 go to 1 from 3");
        step(0, 2'd0, 1, "R7 arrive at 1");
        step(1, 2'd3, 0, "R4 go to 3 from 1");
        step(0, 2'd0, 1, "R7 arrive at 3 again");

        for (int i = 0; i < 3000; i++) begin
            bit rq = ($urandom_range(0, 2) != 0);
            bit ar = ($urandom_range(0, 3) == 0);
            logic [1:0] fl = 2'($urandom_range(0, 3));
            step(rq, fl, ar, "R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule